// File: doc/BRIEF.md
# Double-Buffered Waveform Step Sequencer

This block sequences playback of a stored pulse-train waveform that lives in two memory banks. One bank is scanned step by step for playback while the host rewrites the other bank. A scan address advances on each step strobe from a timing source. When the address reaches the last step of the waveform, the block acts on the host's requests at that boundary and nowhere else. It can swap banks and adopt a new waveform length, restart the scan, or stop.

The host gives a run level, a sticky swap request, a burst/continuous choice, a scan direction and the staged length for the next waveform. Generation can be gated by an external start input. That input is synchronized, and only its rising edge opens the gate. The bank-select output steers the playback path to one bank. The host uses the other bank.

Top module: `ws_seq`

## Requirements
- R1: During and right after reset the block is idle: scan_addr_o = 0, bank_sel_o = 0, active_o = 0, swap_pending_o = 0, swap_ack_o = 0.
- R2: While idle with ext_start_en_i = 0, run_i = 1 makes active_o = 1 one clock later. The top register is loaded from staged_top_i and the scan direction from reverse_i. scan_addr_o starts at 0 when going forward and at the loaded top when reversed.
- R3: While running forward, a step strobe that is not at the end raises scan_addr_o by one. A cycle with step_i = 0 leaves scan_addr_o unchanged.
- R4: A step strobe at the end of the waveform (scan_addr_o equal to top when forward) is the wrap point. In continuous mode (burst_i = 0) with run_i = 1, the very next address is the first step of a new scan, with no idle step between.
- R5: At the end of the waveform with a swap pending, bank_sel_o inverts, top is reloaded from staged_top_i and swap_ack_o pulses for one cycle. Without a pending swap, bank_sel_o and top stay as they were, whatever staged_top_i holds.
- R6: A swap_req_i pulse sets swap_pending_o, which stays set until the next end-of-waveform takes it. A request arriving in the same cycle as that end stays pending for the following end.
- R7: run_i = 0 stops generation only at the end of the waveform. After that end step, active_o = 0 and scan_addr_o = 0. A low run_i in mid-scan does not shorten the scan.
- R8: In burst mode (burst_i = 1) the scan that reaches its end stops, as in R7.
- R9: In reverse mode the scan counts down from top, one per strobe, and address 0 is the end. A new scan starts again at top, using the top value that holds after any swap.
- R10: With ext_start_en_i = 1, run_i = 1 arms the block but does not start it. Generation begins only after a rising edge of ext_start_i passes a two-flop synchronizer and an edge detector. This takes at most four clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Host run level; low requests a stop at the next end |
| burst_i | input | 1 | 1 = play once then stop, 0 = repeat |
| reverse_i | input | 1 | 1 = scan from top down to zero |
| ext_start_en_i | input | 1 | Require an external start edge before generating |
| ext_start_i | input | 1 | Asynchronous external start |
| swap_req_i | input | 1 | Pulse: request a bank swap at the next end |
| step_i | input | 1 | Step strobe, one cycle per waveform step |
| staged_top_i | input | AW | Address of the last step of the prepared waveform |
| bank_sel_o | output | 1 | Bank used for playback; host owns the other |
| scan_addr_o | output | AW | Current playback step address |
| active_o | output | 1 | Generation in progress |
| swap_pending_o | output | 1 | A swap request awaits the end of the waveform |
| swap_ack_o | output | 1 | One-cycle pulse when a swap is taken |

## Verification
The assertions assume that step_i is a synchronous strobe and that run_i, burst_i, reverse_i and staged_top_i are stable across the clock edge where they are sampled. They make no assumption about how often strobes arrive. Only ext_start_i may change asynchronously. The random stimulus changes every synchronous input once per cycle, away from the edge. Staged lengths stay small, including zero, so that wraps, swaps and stops happen often. The external start is exercised in its own directed phase.

// File: rtl/ws_pkg.sv
package ws_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } ws_state_e;
endpackage

// File: rtl/ws_start_sync.sv
module ws_start_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ws_scan_step.sv
module ws_scan_step #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] top_i,
    input  logic          down_i,
    output logic          at_end_o,
    output logic [AW-1:0] addr_next_o
);
    always_comb begin
        if (down_i) begin
            at_end_o    = (addr_i == '0);
            addr_next_o = addr_i - AW'(1);
        end else begin
            at_end_o    = (addr_i == top_i);
            addr_next_o = addr_i + AW'(1);
        end
    end
endmodule

// File: rtl/ws_seq.sv
module ws_seq
    import ws_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          burst_i,
    input  logic          reverse_i,
    input  logic          ext_start_en_i,
    input  logic          ext_start_i,
    input  logic          swap_req_i,
    input  logic          step_i,
    input  logic [AW-1:0] staged_top_i,
    output logic          bank_sel_o,
    output logic [AW-1:0] scan_addr_o,
    output logic          active_o,
    output logic          swap_pending_o,
    output logic          swap_ack_o
);
    typedef struct packed {
        ws_state_e     state;
        logic [AW-1:0] addr;
        logic [AW-1:0] top;
        logic          down;
        logic          bank;
        logic          pend;
        logic          ack;
    } seq_t;

    seq_t          seq_q, seq_d;
    logic          ext_rise;
    logic          at_end;
    logic [AW-1:0] addr_next;
    logic [AW-1:0] top_new;
    logic          take_swap;

    ws_start_sync #(.STAGES(2)) u_start_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(ext_start_i),
        .rise_o (ext_rise)
    );

    ws_scan_step #(.AW(AW)) u_scan_step (
        .addr_i     (seq_q.addr),
        .top_i      (seq_q.top),
        .down_i     (seq_q.down),
        .at_end_o   (at_end),
        .addr_next_o(addr_next)
    );

    always_comb begin
        seq_d     = seq_q;
        seq_d.ack = 1'b0;
        take_swap = 1'b0;
        top_new   = seq_q.top;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (run_i) begin
                    if (ext_start_en_i) begin
                        seq_d.state = ST_ARMED;
                    end else begin
                        seq_d.state = ST_RUN;
                        seq_d.top   = staged_top_i;
                        seq_d.down  = reverse_i;
                        seq_d.addr  = reverse_i ? staged_top_i : '0;
                    end
                end
            end
            ST_ARMED: begin
                if (!run_i) begin
                    seq_d.state = ST_IDLE;
                end else if (ext_rise) begin
                    seq_d.state = ST_RUN;
                    seq_d.top   = staged_top_i;
                    seq_d.down  = reverse_i;
                    seq_d.addr  = reverse_i ? staged_top_i : '0;
                end
            end
            ST_RUN: begin
                if (step_i) begin
                    if (at_end) begin
                        take_swap = seq_q.pend;
                        if (take_swap) begin
                            seq_d.bank = ~seq_q.bank;
                            top_new    = staged_top_i;
                            seq_d.ack  = 1'b1;
                        end
                        seq_d.top = top_new;
                        if (!run_i || burst_i) begin
                            seq_d.state = ST_IDLE;
                            seq_d.addr  = '0;
                            seq_d.down  = 1'b0;
                        end else begin
                            seq_d.down = reverse_i;
                            seq_d.addr = reverse_i ? top_new : '0;
                        end
                    end else begin
                        seq_d.addr = addr_next;
                    end
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
        seq_d.pend = (seq_q.pend & ~take_swap) | swap_req_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state <= ST_IDLE;
            seq_q.addr  <= '0;
            seq_q.top   <= '0;
            seq_q.down  <= 1'b0;
            seq_q.bank  <= 1'b0;
            seq_q.pend  <= 1'b0;
            seq_q.ack   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign bank_sel_o     = seq_q.bank;
    assign scan_addr_o    = seq_q.addr;
    assign active_o       = (seq_q.state == ST_RUN);
    assign swap_pending_o = seq_q.pend;
    assign swap_ack_o     = seq_q.ack;

    // R3: forward strobe away from the end advances by one
    a_r3_fwd_step: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_RUN && step_i && !at_end && !seq_q.down)
        |=> (scan_addr_o == $past(scan_addr_o) + AW'(1)));

    // R9: reverse strobe away from the end steps down by one
    a_r9_rev_step: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_RUN && step_i && !at_end && seq_q.down)
        |=> (scan_addr_o == $past(scan_addr_o) - AW'(1)));

    // R4: continuous forward wrap goes straight to address zero
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_RUN && step_i && at_end && run_i && !burst_i && !reverse_i)
        |=> (scan_addr_o == '0 && active_o));

    // R5: the bank changes only together with an acknowledge
    a_r5_bank_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sel_o != $past(bank_sel_o)) |-> swap_ack_o);

    // R5: the length register holds during a scan
    a_r5_top_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_RUN && !(step_i && at_end)) |=> $stable(seq_q.top));

    // R6: a taken swap clears the pending flag unless re-requested
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_ack_o && !$past(swap_req_i)) |-> !swap_pending_o);

    // R7: idle always parks the address at zero
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_IDLE) |-> (scan_addr_o == '0));

    // R10: armed waits for the synchronized edge
    a_r10_armed_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_ARMED && !ext_rise) |=> !active_o);
endmodule

// File: tb/ws_seq_bench.sv
module ws_seq_bench;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_i = 1'b0, burst_i = 1'b0, reverse_i = 1'b0;
    logic          ext_start_en_i = 1'b0, ext_start_i = 1'b0;
    logic          swap_req_i = 1'b0, step_i = 1'b0;
    logic [AW-1:0] staged_top_i = '0;
    logic          bank_sel_o, active_o, swap_pending_o, swap_ack_o;
    logic [AW-1:0] scan_addr_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // bench model state
    bit          m_act, m_down, m_bank, m_pend, m_ack;
    logic [AW-1:0] m_addr, m_top;

    always #2 clk = ~clk;

    ws_seq #(.AW(AW)) u_ws_seq (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .burst_i(burst_i),
        .reverse_i(reverse_i), .ext_start_en_i(ext_start_en_i),
        .ext_start_i(ext_start_i), .swap_req_i(swap_req_i), .step_i(step_i),
        .staged_top_i(staged_top_i), .bank_sel_o(bank_sel_o),
        .scan_addr_o(scan_addr_o), .active_o(active_o),
        .swap_pending_o(swap_pending_o), .swap_ack_o(swap_ack_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_act = 0; m_down = 0; m_bank = 0; m_pend = 0; m_ack = 0;
        m_addr = '0; m_top = '0;
    endtask

    // next state from the requirements, external start disabled
    task automatic model_step(input bit r, input bit s, input bit sw, input bit b,
                              input bit rv, input logic [AW-1:0] t);
        bit take;
        bit fin;
        take = 0;
        m_ack = 0;
        if (!m_act) begin
            if (r) begin
                m_act = 1; m_top = t; m_down = rv;
                m_addr = rv ? t : '0;
            end
        end else if (s) begin
            fin = m_down ? (m_addr == 0) : (m_addr == m_top);
            if (fin) begin
                take = m_pend;
                if (take) begin
                    m_bank = ~m_bank; m_top = t; m_ack = 1;
                end
                if (!r || b) begin
                    m_act = 0; m_addr = '0; m_down = 0;
                end else begin
                    m_down = rv;
                    m_addr = rv ? m_top : '0;
                end
            end else begin
                m_addr = m_down ? m_addr - 1'b1 : m_addr + 1'b1;
            end
        end
        m_pend = (m_pend & ~take) | sw;
    endtask

    task automatic compare_all(input string req);
        chk(req, "scan_addr", int'(scan_addr_o), int'(m_addr));
        chk(req, "active", int'(active_o), int'(m_act));
        chk(req, "bank_sel", int'(bank_sel_o), int'(m_bank));
        chk(req, "swap_pending", int'(swap_pending_o), int'(m_pend));
        chk(req, "swap_ack", int'(swap_ack_o), int'(m_ack));
    endtask

    task automatic cycle(input string req, input bit r, input bit s, input bit sw,
                         input bit b, input bit rv, input logic [AW-1:0] t);
        @(negedge clk);
        compare_all(req);
        run_i = r; step_i = s; swap_req_i = sw; burst_i = b;
        reverse_i = rv; staged_top_i = t;
        model_step(r, s, sw, b, rv, t);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        run_i = 0; step_i = 0; swap_req_i = 0; burst_i = 0; reverse_i = 0;
        ext_start_en_i = 0; ext_start_i = 0; staged_top_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    initial begin
        void'($urandom(32'd4711));
        do_reset();
        // R1 reset state
        chk("R1", "scan_addr", int'(scan_addr_o), 0);
        chk("R1", "active", int'(active_o), 0);
        chk("R1", "bank_sel", int'(bank_sel_o), 0);
        chk("R1", "swap_pending", int'(swap_pending_o), 0);
        chk("R1", "swap_ack", int'(swap_ack_o), 0);

        // R10 external start gate
        ext_start_en_i = 1; run_i = 1; staged_top_i = 8'd5;
        repeat (6) @(negedge clk);
        chk("R10", "active_before_edge", int'(active_o), 0);
        ext_start_i = 1;
        repeat (5) @(negedge clk);
        chk("R10", "active_after_edge", int'(active_o), 1);
        chk("R10", "scan_addr", int'(scan_addr_o), 0);

        do_reset();
        // R2 start with length 2
        cycle("R2", 1, 0, 0, 0, 0, 8'd2);
        cycle("R2", 1, 0, 0, 0, 0, 8'd9);
        // R3 R4 forward steps and wrap
        for (int i = 0; i < 8; i++) cycle("R4", 1, 1, 0, 0, 0, 8'd9);
        // R5 swap to new length 4
        cycle("R5", 1, 0, 1, 0, 0, 8'd4);
        for (int i = 0; i < 10; i++) cycle("R5", 1, 1, 0, 0, 0, 8'd4);
        // R6 sticky request held across a scan
        cycle("R6", 1, 0, 1, 0, 0, 8'd1);
        for (int i = 0; i < 8; i++) cycle("R6", 1, i[0], 0, 0, 0, 8'd1);
        // R7 run low mid-scan
        cycle("R7", 1, 1, 0, 0, 0, 8'd1);
        for (int i = 0; i < 4; i++) cycle("R7", 0, 1, 0, 0, 0, 8'd3);
        // R8 burst one pass
        for (int i = 0; i < 8; i++) cycle("R8", 1, 1, 0, 1, 0, 8'd3);
        // R9 reverse scans
        for (int i = 0; i < 6; i++) cycle("R9", 0, 1, 0, 0, 1, 8'd3);
        for (int i = 0; i < 12; i++) cycle("R9", 1, 1, i == 3, 0, 1, 8'd2);

        // R3 random mix
        for (int i = 0; i < 4000; i++) begin
            cycle("R3", ($urandom % 10) != 0, $urandom % 2,
                  ($urandom % 20) == 0, ($urandom % 12) == 0,
                  ($urandom % 5) == 0, AW'($urandom % 7));
        end
        @(negedge clk);
        compare_all("R3");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule